// File: doc/BRIEF.md
# Converter Power Sequencer

This block sequences power for a mixed-signal converter core. It watches an active-low reset pin, an active-low hard power-down pin and a software power-down bit. From these it drives a reference-enable line, one enable per function block and a data-valid flag. Every wait is counted in ticks of an external timebase, so the same logic serves microsecond-scale and millisecond-scale intervals.

The block also holds the small configuration register. Its low bits switch individual function blocks off. The register is only cleared by a reset pulse that was held long enough. Sleeping and waking never disturb it.

The cost of waking depends on how the core went to sleep. A hard power-down turns the reference off, so waking from it needs the long reference settle. A software power-down leaves the reference running, so waking from it needs only a short restart.

Top module: `pwr_seq_top`

## Requirements
- R1: When `hpd_n` is low at a clock edge, `ref_en`, every `blk_en` bit and `data_valid` are all low after that edge.
- R2: Priority is fixed. A low `rst_pin_n` overrides everything. A low `hpd_n` overrides `sw_pd`. If `rst_pin_n` is released while `hpd_n` is still low, the core stays fully off.
- R3: A reset is accepted as valid once `rst_pin_n` has been low for at least `HOLD_T` ticks. An accepted reset returns `cfg_q` to `CFG_INIT`, which is all zeros by default. A shorter low pulse leaves `cfg_q` unchanged.
- R4: After `rst_pin_n` is released, `ref_en` is high and `data_valid` stays low for `LONG_T` ticks. After that, `data_valid` rises.
- R5: After `hpd_n` returns high, the same `LONG_T`-tick settle with the reference on comes before `data_valid` rises.
- R6: While software power-down holds, `ref_en` stays high and every `blk_en` bit is low.
- R7: When `sw_pd` falls, the blocks are enabled at once and `data_valid` rises after `SHORT_T` ticks.
- R8: `cfg_q` keeps its value across every kind of wake-up. A write (`cfg_we`) loads `cfg_wd` at the next edge unless `rst_pin_n` is low, in which case the write is ignored.
- R9: Bit i of `cfg_q` (i < `NBLK`) set to 1 powers block i down. While the core is awake or restarting, `blk_en[i]` equals the inverse of that bit.
- R10: `data_valid` is low at the first clock edge after any power-down or reset input is asserted.
- R11: If `sw_pd` is high when the long settle ends, the core goes straight to software power-down and `data_valid` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_n | input | 1 | Active-low reset pin |
| hpd_n | input | 1 | Active-low hard power-down pin |
| sw_pd | input | 1 | Software power-down bit |
| tick | input | 1 | One-cycle timebase pulse |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wd | input | CFG_W | Configuration write data |
| cfg_q | output | CFG_W | Configuration register contents |
| ref_en | output | 1 | Reference enable |
| blk_en | output | NBLK | Per-block enables |
| data_valid | output | 1 | Converter data valid |

## Verification
The bench builds the block with `HOLD_T`=6, `LONG_T`=40, `SHORT_T`=5 and a tick every third clock. At these values the long settle takes about 120 cycles rather than the 100000 ticks of the default. This lets the bench cover in one short run a reset rejected for being too short, several hard and software wake-ups, and a software power-down that arrives during a long settle. With `NBLK`=4 every block mask pattern stays visible on `blk_en`.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_RESET  = 3'd0,
        ST_SETTLE = 3'd1,
        ST_RUN    = 3'd2,
        ST_SWPD   = 3'd3,
        ST_HWPD   = 3'd4,
        ST_SWAKE  = 3'd5
    } seq_state_e;

    typedef struct packed {
        logic rst_low;
        logic hpd_low;
        logic sw_req;
        logic tick;
    } seq_in_t;

    function automatic logic ref_on(input seq_state_e s);
        return (s == ST_SETTLE) || (s == ST_RUN) || (s == ST_SWPD) || (s == ST_SWAKE);
    endfunction

    function automatic logic core_on(input seq_state_e s);
        return (s == ST_RUN) || (s == ST_SWAKE);
    endfunction

endpackage

// File: rtl/pwr_seq_fsm.sv
module pwr_seq_fsm
    import pwr_seq_pkg::*;
#(
    parameter int HOLD_T  = 20,
    parameter int LONG_T  = 100000,
    parameter int SHORT_T = 20
) (
    input  logic       clk,
    input  logic       rst,
    input  seq_in_t    in_i,
    output seq_state_e state_o,
    output logic       cfg_clr_o
);
    localparam int CNT_MAX = (HOLD_T > LONG_T) ? ((HOLD_T > SHORT_T) ? HOLD_T : SHORT_T)
                                               : ((LONG_T > SHORT_T) ? LONG_T : SHORT_T);
    localparam int CNT_W = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] HOLD_LIM  = CNT_W'(HOLD_T);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(LONG_T - 1);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(SHORT_T - 1);

    seq_state_e       st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, lim;
    logic             at_lim;

    always_comb begin
        case (st_q)
            ST_RESET:  lim = HOLD_LIM;
            ST_SETTLE: lim = LONG_LIM;
            ST_SWAKE:  lim = SHORT_LIM;
            default:   lim = '0;
        endcase
    end

    assign at_lim = in_i.tick && (cnt_q == lim);

    always_comb begin
        st_nx = st_q;
        if (in_i.rst_low) begin
            st_nx = ST_RESET;
        end else begin
            case (st_q)
                ST_RESET, ST_HWPD:
                    st_nx = in_i.hpd_low ? ST_HWPD : ST_SETTLE;
                ST_SETTLE:
                    if (in_i.hpd_low)  st_nx = ST_HWPD;
                    else if (at_lim)   st_nx = in_i.sw_req ? ST_SWPD : ST_RUN;
                ST_RUN:
                    if (in_i.hpd_low)     st_nx = ST_HWPD;
                    else if (in_i.sw_req) st_nx = ST_SWPD;
                ST_SWPD:
                    if (in_i.hpd_low)      st_nx = ST_HWPD;
                    else if (!in_i.sw_req) st_nx = ST_SWAKE;
                ST_SWAKE:
                    if (in_i.hpd_low)     st_nx = ST_HWPD;
                    else if (in_i.sw_req) st_nx = ST_SWPD;
                    else if (at_lim)      st_nx = ST_RUN;
                default:
                    st_nx = ST_RESET;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RESET;
            cnt_q <= '0;
        end else begin
            st_q <= st_nx;
            if (st_nx != st_q)
                cnt_q <= '0;
            else if (in_i.tick && (cnt_q < lim))
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state_o   = st_q;
    assign cfg_clr_o = (st_q == ST_RESET) && (cnt_q >= HOLD_LIM);

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_W'(CNT_MAX));

    // R2
    rst_prio_chk: assert property (@(posedge clk) disable iff (rst)
        in_i.rst_low |=> (st_q == ST_RESET));

endmodule

// File: rtl/pwr_cfg_reg.sv
module pwr_cfg_reg #(
    parameter int              CFG_W    = 8,
    parameter logic [CFG_W-1:0] CFG_INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             lock_i,
    input  logic             we_i,
    input  logic [CFG_W-1:0] wd_i,
    output logic [CFG_W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            q_o <= CFG_INIT;
        else if (we_i && !lock_i)
            q_o <= wd_i;
    end

    // R8
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((!we_i || lock_i) && !clr_i) |=> $stable(q_o));

endmodule

// File: rtl/pwr_out_dec.sv
module pwr_out_dec
    import pwr_seq_pkg::*;
#(
    parameter int NBLK = 4
) (
    input  seq_state_e      state_i,
    input  logic [NBLK-1:0] blk_off_i,
    output logic            ref_en_o,
    output logic            valid_o,
    output logic [NBLK-1:0] blk_en_o
);
    logic awake;

    assign awake    = core_on(state_i);
    assign ref_en_o = ref_on(state_i);
    assign valid_o  = (state_i == ST_RUN);

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assign blk_en_o[i] = awake && !blk_off_i[i];
    end

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int               NBLK     = 4,
    parameter int               CFG_W    = 8,
    parameter logic [CFG_W-1:0] CFG_INIT = '0,
    parameter int               HOLD_T   = 20,
    parameter int               LONG_T   = 100000,
    parameter int               SHORT_T  = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rst_pin_n,
    input  logic             hpd_n,
    input  logic             sw_pd,
    input  logic             tick,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wd,
    output logic [CFG_W-1:0] cfg_q,
    output logic             ref_en,
    output logic [NBLK-1:0]  blk_en,
    output logic             data_valid
);
    seq_in_t    sin;
    seq_state_e st;
    logic       cfg_clr;

    assign sin = '{rst_low: !rst_pin_n, hpd_low: !hpd_n, sw_req: sw_pd, tick: tick};

    pwr_seq_fsm #(.HOLD_T(HOLD_T), .LONG_T(LONG_T), .SHORT_T(SHORT_T)) u_fsm (
        .clk(clk), .rst(rst), .in_i(sin), .state_o(st), .cfg_clr_o(cfg_clr)
    );

    pwr_cfg_reg #(.CFG_W(CFG_W), .CFG_INIT(CFG_INIT)) u_cfg (
        .clk(clk), .rst(rst), .clr_i(cfg_clr), .lock_i(!rst_pin_n),
        .we_i(cfg_we), .wd_i(cfg_wd), .q_o(cfg_q)
    );

    pwr_out_dec #(.NBLK(NBLK)) u_dec (
        .state_i(st), .blk_off_i(cfg_q[NBLK-1:0]),
        .ref_en_o(ref_en), .valid_o(data_valid), .blk_en_o(blk_en)
    );

    // R1
    hpd_off_chk: assert property (@(posedge clk) disable iff (rst)
        !hpd_n |=> (!ref_en && (blk_en == '0) && !data_valid));

    // R10
    valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_pd || !hpd_n || !rst_pin_n) |=> !data_valid);

    // R6
    spd_ref_chk: assert property (@(posedge clk) disable iff (rst)
        (data_valid && sw_pd && hpd_n && rst_pin_n) |=> (ref_en && (blk_en == '0)));

    // R4
    valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(data_valid) |-> $past(ref_en));

endmodule

// File: tb/sim_pwr_seq_top.sv
module sim_pwr_seq_top;
    localparam int NBLK = 4, CFG_W = 8, HOLD_T = 6, LONG_T = 40, SHORT_T = 5;

    logic clk = 0, rst, rst_pin_n, hpd_n, sw_pd, tick, cfg_we;
    logic [CFG_W-1:0] cfg_wd, cfg_q;
    logic ref_en, data_valid;
    logic [NBLK-1:0] blk_en;

    int n_run = 0, n_fail = 0, tdiv = 0;
    bit started = 0, finished = 0;
    string tag = "R4";

    // behavioural model: 0 reset,1 settle,2 run,3 sw pd,4 hw pd,5 sw wake
    int ms, mc, nx, lim;
    logic [CFG_W-1:0] mcfg;

    always #5 clk = ~clk;

    pwr_seq_top #(.NBLK(NBLK), .CFG_W(CFG_W), .HOLD_T(HOLD_T), .LONG_T(LONG_T),
                  .SHORT_T(SHORT_T)) u0 (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .hpd_n(hpd_n), .sw_pd(sw_pd),
        .tick(tick), .cfg_we(cfg_we), .cfg_wd(cfg_wd), .cfg_q(cfg_q),
        .ref_en(ref_en), .blk_en(blk_en), .data_valid(data_valid)
    );

    always @(posedge clk) begin
        started <= 1;
        if (rst) begin
            ms <= 0; mc <= 0; mcfg <= '0;
        end else begin
            lim = (ms == 0) ? HOLD_T : (ms == 1) ? LONG_T - 1 : (ms == 5) ? SHORT_T - 1 : 0;
            if (!rst_pin_n) nx = 0;
            else if (ms == 0 || ms == 4) nx = !hpd_n ? 4 : 1;
            else if (!hpd_n) nx = 4;
            else if (ms == 1) nx = (tick && mc == lim) ? (sw_pd ? 3 : 2) : 1;
            else if (ms == 2) nx = sw_pd ? 3 : 2;
            else if (ms == 3) nx = sw_pd ? 3 : 5;
            else nx = sw_pd ? 3 : ((tick && mc == lim) ? 2 : 5);
            if (ms == 0 && mc >= HOLD_T) mcfg <= '0;
            else if (cfg_we && rst_pin_n) mcfg <= cfg_wd;
            if (nx != ms) mc <= 0;
            else if (tick && mc < lim) mc <= mc + 1;
            ms <= nx;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !finished) begin
            logic [NBLK-1:0] eb;
            logic            er, ev;
            er = (ms == 1 || ms == 2 || ms == 3 || ms == 5);
            ev = (ms == 2);
            eb = (ms == 2 || ms == 5) ? ~mcfg[NBLK-1:0] : '0;
            chk({ref_en, data_valid, blk_en, cfg_q} == {er, ev, eb, mcfg}, tag,
                {ref_en, data_valid, blk_en, cfg_q}, {er, ev, eb, mcfg});
        end
        tdiv = (tdiv == 2) ? 0 : tdiv + 1;
        tick = (tdiv == 2);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [CFG_W-1:0] v);
        cfg_we = 1; cfg_wd = v; cyc(1); cfg_we = 0;
    endtask

    initial begin
        rst = 1; rst_pin_n = 0; hpd_n = 1; sw_pd = 0; tick = 0; cfg_we = 0; cfg_wd = '0;
        cyc(3);
        chk(!ref_en && !data_valid && cfg_q == 0, "R3 reset state", {ref_en, data_valid, cfg_q}, 0);
        rst = 0;
        tag = "R3"; cyc(25);
        wr(8'hAA);
        chk(cfg_q == 0, "R8 write ignored in reset", cfg_q, 0);
        rst_pin_n = 1; tag = "R4"; cyc(20);
        chk(ref_en && !data_valid, "R4 settling", {ref_en, data_valid}, 2'b10);
        cyc(115);
        chk(data_valid && blk_en == 4'hF, "R4 valid after settle", {data_valid, blk_en}, 5'h1F);
        tag = "R9"; wr(8'h05); cyc(1);
        chk(blk_en == 4'b1010, "R9 block mask", blk_en, 4'b1010);
        tag = "R6"; sw_pd = 1; cyc(1);
        chk(!data_valid, "R10 sw pd valid drop", data_valid, 0);
        chk(ref_en && blk_en == 0, "R6 ref kept", {ref_en, blk_en}, 5'h10);
        cyc(20);
        tag = "R7"; sw_pd = 0; cyc(1);
        chk(!data_valid && blk_en == 4'b1010, "R7 restart", {data_valid, blk_en}, 5'h0A);
        cyc(20);
        chk(data_valid && cfg_q == 8'h05, "R8 cfg after sw wake", {data_valid, cfg_q}, 9'h105);
        tag = "R1"; hpd_n = 0; cyc(1);
        chk(!ref_en && !data_valid && blk_en == 0, "R1 hard pd", {ref_en, data_valid, blk_en}, 0);
        tag = "R2"; sw_pd = 1; cyc(10);
        chk(!ref_en, "R2 hard over soft", ref_en, 0);
        sw_pd = 0; hpd_n = 1; tag = "R5"; cyc(30);
        chk(ref_en && !data_valid, "R5 long settle", {ref_en, data_valid}, 2'b10);
        cyc(105);
        chk(data_valid && cfg_q == 8'h05, "R8 cfg after hard wake", {data_valid, cfg_q}, 9'h105);
        tag = "R3"; rst_pin_n = 0; cyc(1);
        chk(!data_valid, "R10 reset valid drop", data_valid, 0);
        cyc(5); rst_pin_n = 1; cyc(2);
        chk(cfg_q == 8'h05, "R3 short pulse keeps cfg", cfg_q, 8'h05);
        tag = "R2"; hpd_n = 0; rst_pin_n = 0; cyc(25); rst_pin_n = 1; cyc(10);
        chk(!ref_en && cfg_q == 0, "R2 hpd holds after reset", {ref_en, cfg_q}, 0);
        tag = "R11"; hpd_n = 1; cyc(60); sw_pd = 1; cyc(90);
        chk(ref_en && !data_valid && blk_en == 0, "R11 settle into sw pd",
            {ref_en, data_valid, blk_en}, 6'h20);
        sw_pd = 0; cyc(25);
        chk(data_valid, "R7 wake after R11", data_valid, 1);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        cyc(20000);
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule